// File: doc/BRIEF.md
# Receive Sampling-Delay Tuning Engine

This block is a hardware sequencer that searches for the best receive data sampling delay of a card interface. When started in one of the two fastest single-data-rate timing modes, it walks a tune value upward from zero across a fixed window of steps. For every step it drives the value onto the delay-control field and commits it twice through a self-clearing update handshake with the delay line. It then asks an external tuning-command responder for a pass or fail verdict at that delay.

While scanning, the engine tracks runs of consecutive passing steps. It remembers the longest run and the step where that run ends. After the last step it commits the delay in the middle of that run, again with two update handshakes, or it reports that no working point exists. In every other timing mode a start request completes at once and leaves the delay untouched. A handshake or verdict that does not arrive within a bounded number of cycles fails its step, so the scan always terminates.

Top module: `rx_tune_engine`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `err_o`, `upd_req_o` and `test_req_o` are low and `tune_val_o` is zero.
- R2: A start while `mode_i` is neither 3'd6 nor 3'd7 raises `done_o` at the next clock edge and clears `err_o`. It never raises `busy_o` or `upd_req_o`, and `tune_val_o` keeps its previous value.
- R3: A start in mode 3'd6 or 3'd7 scans steps 0 to NUM_STEPS-1 (0 to 39 by default) in increasing order. At most one test request is issued per step, and during each request `tune_val_o` equals the step index. `tune_val_o` never reaches NUM_STEPS or more.
- R4: Before a step is tested, its value is committed by two complete update handshakes. `upd_req_o` rises, stays high with `tune_val_o` stable until `upd_ack_i` is seen, then falls. Update and test requests are never high together.
- R5: With at least one passing step, the final `tune_val_o` is E - floor(L/2), where L is the length of the longest run of consecutive passes and E is its last step. Among runs of equal length the earliest wins. The final value is committed by two more update handshakes, after which `done_o` is high and `err_o` low.
- R6: When no step passes, `err_o` and `done_o` go high, no final update is issued, and `tune_val_o` holds NUM_STEPS-1.
- R7: If `upd_ack_i` does not arrive within TIMEOUT_CYC cycles of the request, the request is dropped and the step counts as failed with no test request for it.
- R8: If `test_done_i` does not arrive within TIMEOUT_CYC cycles of a test request, the step counts as failed.
- R9: `busy_o` is high from the cycle after an accepted start until completion, and `done_o` and `busy_o` are never high together. A start while busy is ignored and leaves the result unchanged. An accepted start clears `done_o` and `err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a tuning run (one cycle) |
| mode_i | input | 3 | Current bus timing mode; 3'd6 and 3'd7 are the tunable modes |
| tune_val_o | output | TUNE_W | Sampling-delay tune value |
| upd_req_o | output | 1 | Delay-update request, held until acknowledged or timed out |
| upd_ack_i | input | 1 | Delay line reports the update has taken effect |
| test_req_o | output | 1 | Ask the responder to test the current delay |
| test_done_i | input | 1 | Responder verdict is valid |
| test_pass_i | input | 1 | Verdict: 1 = pass, 0 = fail |
| busy_o | output | 1 | Scan or final commit in progress |
| done_o | output | 1 | Last request finished (held until the next accepted start) |
| err_o | output | 1 | Last scan found no working point |

## Verification
The bench keeps the default 40-step window and 6-bit tune field but shrinks TIMEOUT_CYC to 16. This brings both timeout paths, a dropped update and a missing verdict, within a few dozen cycles of a normal step. With that setting, whole scans with tied runs, runs at either edge of the window, odd and even run lengths and the empty case all fit in one short run. The bench's responder counts update and test requests per scan, so the double commit, the skipped test after a dropped update and the absence of a final commit after a failed scan are all visible at the ports.

// File: rtl/rte_pkg.sv
package rte_pkg;

  localparam int MODE_W = 3;

  // timing-mode codes for which the scan is performed
  localparam logic [MODE_W-1:0] MODE_FAST_A = 3'd6;
  localparam logic [MODE_W-1:0] MODE_FAST_B = 3'd7;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_APPLY,
    ST_APPLY_WAIT,
    ST_TEST,
    ST_TEST_WAIT,
    ST_STEP_END,
    ST_PICK,
    ST_FINAL,
    ST_FINAL_WAIT
  } rte_state_e;

  function automatic logic mode_is_tunable(input logic [MODE_W-1:0] m);
    return (m == MODE_FAST_A) || (m == MODE_FAST_B);
  endfunction

endpackage

// File: rtl/rte_hs_timer.sv
// Request/acknowledge handshake with a bounded wait.
module rte_hs_timer #(
  parameter int TMO_CYC = 1024,
  localparam int CNT_W  = $clog2(TMO_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go_i,
  input  logic ack_i,
  output logic req_o,
  output logic fin_o,
  output logic tmo_o
);

  logic             req_q, req_d;
  logic             fin_q, fin_d;
  logic             tmo_q, tmo_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    req_d = req_q;
    cnt_d = cnt_q;
    fin_d = 1'b0;
    tmo_d = 1'b0;
    if (req_q) begin
      if (ack_i) begin
        req_d = 1'b0;
        fin_d = 1'b1;
      end else if (cnt_q == CNT_W'(TMO_CYC - 1)) begin
        req_d = 1'b0;
        fin_d = 1'b1;
        tmo_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else if (go_i) begin
      req_d = 1'b1;
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      fin_q <= 1'b0;
      tmo_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      req_q <= req_d;
      fin_q <= fin_d;
      tmo_q <= tmo_d;
      cnt_q <= cnt_d;
    end
  end

  assign req_o = req_q;
  assign fin_o = fin_q;
  assign tmo_o = tmo_q;

endmodule

// File: rtl/rte_run_track.sv
// Tracks consecutive-pass runs and the longest one seen.
module rte_run_track #(
  parameter int NUM_STEPS = 40,
  parameter int IDX_W     = 6,
  localparam int LEN_W    = $clog2(NUM_STEPS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             upd_i,
  input  logic             pass_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [IDX_W-1:0] centre_o,
  output logic             any_pass_o
);

  logic [LEN_W-1:0] cur_q, cur_d;
  logic [LEN_W-1:0] best_q, best_d;
  logic [IDX_W-1:0] end_q, end_d;
  logic [LEN_W-1:0] cur_inc;

  assign cur_inc = cur_q + 1'b1;

  always_comb begin
    cur_d  = cur_q;
    best_d = best_q;
    end_d  = end_q;
    if (clr_i) begin
      cur_d  = '0;
      best_d = '0;
      end_d  = '0;
    end else if (upd_i) begin
      if (pass_i) begin
        cur_d = cur_inc;
        // strictly longer only: ties keep the earlier run
        if (cur_inc > best_q) begin
          best_d = cur_inc;
          end_d  = idx_i;
        end
      end else begin
        cur_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      best_q <= '0;
      end_q  <= '0;
    end else begin
      cur_q  <= cur_d;
      best_q <= best_d;
      end_q  <= end_d;
    end
  end

  assign centre_o   = end_q - IDX_W'(best_q >> 1);
  assign any_pass_o = (best_q != '0);

endmodule

// File: rtl/rte_seq.sv
// Scan sequencer: steps, double commit, test, pick, final commit.
module rte_seq
  import rte_pkg::*;
#(
  parameter int NUM_STEPS    = 40,
  parameter int TUNE_W       = 6,
  parameter int APPLY_REPEAT = 2,
  localparam int REP_W       = $clog2(APPLY_REPEAT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              upd_fin_i,
  input  logic              upd_tmo_i,
  input  logic              test_req_i,
  input  logic              test_fin_i,
  input  logic              test_tmo_i,
  input  logic              test_done_i,
  input  logic              test_pass_i,
  input  logic [TUNE_W-1:0] centre_i,
  input  logic              any_pass_i,
  output logic              upd_go_o,
  output logic              test_go_o,
  output logic              trk_clr_o,
  output logic              trk_upd_o,
  output logic              trk_pass_o,
  output logic [TUNE_W-1:0] idx_o,
  output logic [TUNE_W-1:0] tune_val_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);

  rte_state_e        st_q, st_d;
  logic [TUNE_W-1:0] idx_q, idx_d;
  logic [TUNE_W-1:0] tune_q, tune_d;
  logic [REP_W-1:0]  rep_q, rep_d;
  logic              verdict_q, verdict_d;
  logic              step_ok_q, step_ok_d;
  logic              done_q, done_d;
  logic              err_q, err_d;
  logic              last_step;
  logic              last_rep;

  assign last_step = (idx_q == TUNE_W'(NUM_STEPS - 1));
  assign last_rep  = (rep_q == REP_W'(APPLY_REPEAT - 1));

  always_comb begin
    st_d       = st_q;
    idx_d      = idx_q;
    tune_d     = tune_q;
    rep_d      = rep_q;
    step_ok_d  = step_ok_q;
    done_d     = done_q;
    err_d      = err_q;
    upd_go_o   = 1'b0;
    test_go_o  = 1'b0;
    trk_clr_o  = 1'b0;
    trk_upd_o  = 1'b0;
    // verdict is captured in the cycle the responder answers
    verdict_d  = (test_req_i && test_done_i) ? test_pass_i : verdict_q;

    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          err_d = 1'b0;
          if (mode_is_tunable(mode_i)) begin
            done_d    = 1'b0;
            idx_d     = '0;
            rep_d     = '0;
            trk_clr_o = 1'b1;
            st_d      = ST_APPLY;
          end else begin
            done_d = 1'b1;
          end
        end
      end
      ST_APPLY: begin
        tune_d   = idx_q;
        upd_go_o = 1'b1;
        st_d     = ST_APPLY_WAIT;
      end
      ST_APPLY_WAIT: begin
        if (upd_fin_i) begin
          if (upd_tmo_i) begin
            step_ok_d = 1'b0;
            rep_d     = '0;
            st_d      = ST_STEP_END;
          end else if (last_rep) begin
            rep_d = '0;
            st_d  = ST_TEST;
          end else begin
            rep_d = rep_q + 1'b1;
            st_d  = ST_APPLY;
          end
        end
      end
      ST_TEST: begin
        test_go_o = 1'b1;
        st_d      = ST_TEST_WAIT;
      end
      ST_TEST_WAIT: begin
        if (test_fin_i) begin
          step_ok_d = !test_tmo_i && verdict_q;
          st_d      = ST_STEP_END;
        end
      end
      ST_STEP_END: begin
        trk_upd_o = 1'b1;
        if (last_step) begin
          st_d = ST_PICK;
        end else begin
          idx_d = idx_q + 1'b1;
          st_d  = ST_APPLY;
        end
      end
      ST_PICK: begin
        if (any_pass_i) begin
          tune_d = centre_i;
          rep_d  = '0;
          st_d   = ST_FINAL;
        end else begin
          err_d  = 1'b1;
          done_d = 1'b1;
          st_d   = ST_IDLE;
        end
      end
      ST_FINAL: begin
        upd_go_o = 1'b1;
        st_d     = ST_FINAL_WAIT;
      end
      ST_FINAL_WAIT: begin
        if (upd_fin_i) begin
          if (upd_tmo_i || last_rep) begin
            done_d = 1'b1;
            rep_d  = '0;
            st_d   = ST_IDLE;
          end else begin
            rep_d = rep_q + 1'b1;
            st_d  = ST_FINAL;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      idx_q     <= '0;
      tune_q    <= '0;
      rep_q     <= '0;
      verdict_q <= 1'b0;
      step_ok_q <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      st_q      <= st_d;
      idx_q     <= idx_d;
      tune_q    <= tune_d;
      rep_q     <= rep_d;
      verdict_q <= verdict_d;
      step_ok_q <= step_ok_d;
      done_q    <= done_d;
      err_q     <= err_d;
    end
  end

  assign trk_pass_o = step_ok_q;
  assign idx_o      = idx_q;
  assign tune_val_o = tune_q;
  assign busy_o     = (st_q != ST_IDLE);
  assign done_o     = done_q;
  assign err_o      = err_q;

endmodule

// File: rtl/rx_tune_engine.sv
module rx_tune_engine
  import rte_pkg::*;
#(
  parameter int NUM_STEPS    = 40,
  parameter int TUNE_W       = 6,
  parameter int APPLY_REPEAT = 2,
  parameter int TIMEOUT_CYC  = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [2:0]        mode_i,
  output logic [TUNE_W-1:0] tune_val_o,
  output logic              upd_req_o,
  input  logic              upd_ack_i,
  output logic              test_req_o,
  input  logic              test_done_i,
  input  logic              test_pass_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);

  logic              upd_go, upd_fin, upd_tmo;
  logic              test_go, test_fin, test_tmo;
  logic              trk_clr, trk_upd, trk_pass;
  logic [TUNE_W-1:0] idx;
  logic [TUNE_W-1:0] centre;
  logic              any_pass;

  rte_hs_timer #(.TMO_CYC(TIMEOUT_CYC)) u_upd_hs (
    .clk   (clk),
    .rst_n (rst_n),
    .go_i  (upd_go),
    .ack_i (upd_ack_i),
    .req_o (upd_req_o),
    .fin_o (upd_fin),
    .tmo_o (upd_tmo)
  );

  rte_hs_timer #(.TMO_CYC(TIMEOUT_CYC)) u_test_hs (
    .clk   (clk),
    .rst_n (rst_n),
    .go_i  (test_go),
    .ack_i (test_done_i),
    .req_o (test_req_o),
    .fin_o (test_fin),
    .tmo_o (test_tmo)
  );

  rte_run_track #(.NUM_STEPS(NUM_STEPS), .IDX_W(TUNE_W)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (trk_clr),
    .upd_i      (trk_upd),
    .pass_i     (trk_pass),
    .idx_i      (idx),
    .centre_o   (centre),
    .any_pass_o (any_pass)
  );

  rte_seq #(
    .NUM_STEPS    (NUM_STEPS),
    .TUNE_W       (TUNE_W),
    .APPLY_REPEAT (APPLY_REPEAT)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .mode_i      (mode_i),
    .upd_fin_i   (upd_fin),
    .upd_tmo_i   (upd_tmo),
    .test_req_i  (test_req_o),
    .test_fin_i  (test_fin),
    .test_tmo_i  (test_tmo),
    .test_done_i (test_done_i),
    .test_pass_i (test_pass_i),
    .centre_i    (centre),
    .any_pass_i  (any_pass),
    .upd_go_o    (upd_go),
    .test_go_o   (test_go),
    .trk_clr_o   (trk_clr),
    .trk_upd_o   (trk_upd),
    .trk_pass_o  (trk_pass),
    .idx_o       (idx),
    .tune_val_o  (tune_val_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o)
  );

endmodule

// File: rtl/rte_checker.sv
module rte_checker #(
  parameter int NUM_STEPS = 40,
  parameter int TUNE_W    = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [TUNE_W-1:0] tune_val_o,
  input logic              upd_req_o,
  input logic              test_req_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o
);

  // R4
  tune_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_req_o && $past(upd_req_o)) |-> (tune_val_o == $past(tune_val_o)));

  // R4
  req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd_req_o && test_req_o));

  // R3
  tune_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tune_val_o < TUNE_W'(NUM_STEPS));

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && busy_o));

  // R9
  req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_req_o || test_req_o) |-> busy_o);

  // R6
  err_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> done_o);

  // R2
  upd_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(upd_req_o) |-> $past(busy_o));

endmodule

bind rx_tune_engine rte_checker #(.NUM_STEPS(NUM_STEPS), .TUNE_W(TUNE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tune_val_o (tune_val_o),
  .upd_req_o  (upd_req_o),
  .test_req_o (test_req_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .err_o      (err_o)
);

// File: tb/sim_rx_tune_engine.sv
module sim_rx_tune_engine;

  localparam int NSTEP = 40;
  localparam int TW    = 6;
  localparam int TMO   = 16;

  typedef struct packed {
    logic [NSTEP-1:0] mask;
    logic [TW-1:0]    val;
    logic             err;
  } vec_t;

  // pass mask (bit i = step i passes), expected final value, expected error
  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{40'hFF_FFFF_FFFF, 6'd19, 1'b0},   // full window
    '{40'h00_000F_FC00, 6'd14, 1'b0},   // 10..19
    '{40'h00_00F0_01E0, 6'd6,  1'b0},   // tie 5..8 / 20..23, first kept
    '{40'hFF_C000_0007, 6'd34, 1'b0},   // short then long at top edge
    '{40'h00_0000_0001, 6'd0,  1'b0},   // single at 0
    '{40'h80_0000_0000, 6'd39, 1'b0},   // single at 39
    '{40'h00_0000_3FB8, 6'd10, 1'b0},   // 3..5 then 7..13
    '{40'h00_01F0_0000, 6'd22, 1'b0},   // odd run 20..24
    '{40'h00_0000_0000, 6'd39, 1'b1}    // nothing passes
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_i;
  logic [2:0]    mode_i;
  logic [TW-1:0] tune_val_o;
  logic          upd_req_o;
  logic          upd_ack_i;
  logic          test_req_o;
  logic          test_done_i;
  logic          test_pass_i;
  logic          busy_o;
  logic          done_o;
  logic          err_o;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  logic [NSTEP-1:0] cur_mask;
  int  hold_upd_idx;
  int  hold_test_idx;
  int  upd_cnt, test_cnt;
  int  upd_rises, test_rises;
  logic upd_prev, test_prev;
  int  last_test_idx;
  logic order_ok;
  logic busy_seen;

  always #2 clk = ~clk;

  rx_tune_engine #(
    .NUM_STEPS(NSTEP), .TUNE_W(TW), .APPLY_REPEAT(2), .TIMEOUT_CYC(TMO)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .tune_val_o(tune_val_o), .upd_req_o(upd_req_o), .upd_ack_i(upd_ack_i),
    .test_req_o(test_req_o), .test_done_i(test_done_i), .test_pass_i(test_pass_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // responder model for the delay line and the tuning-command side
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      upd_ack_i   <= 1'b0;
      test_done_i <= 1'b0;
      test_pass_i <= 1'b0;
      upd_cnt     = 0;
      test_cnt    = 0;
      upd_prev    = 1'b0;
      test_prev   = 1'b0;
    end else begin
      if (upd_req_o && !upd_prev) upd_rises++;
      if (test_req_o && !test_prev) begin
        test_rises++;
        if (int'(tune_val_o) <= last_test_idx) order_ok = 1'b0;
        last_test_idx = int'(tune_val_o);
      end
      if (busy_o) busy_seen = 1'b1;
      upd_prev  = upd_req_o;
      test_prev = test_req_o;
      if (upd_req_o) begin
        upd_cnt++;
        if (upd_cnt >= 2 && int'(tune_val_o) != hold_upd_idx) upd_ack_i <= 1'b1;
      end else begin
        upd_cnt = 0;
        upd_ack_i <= 1'b0;
      end
      if (test_req_o) begin
        test_cnt++;
        if (test_cnt >= 1 && int'(tune_val_o) != hold_test_idx) begin
          test_done_i <= 1'b1;
          test_pass_i <= cur_mask[tune_val_o];
        end
      end else begin
        test_cnt = 0;
        test_done_i <= 1'b0;
        test_pass_i <= 1'b0;
      end
    end
  end

  task automatic clear_stats();
    upd_rises     = 0;
    test_rises    = 0;
    last_test_idx = -1;
    order_ok      = 1'b1;
    busy_seen     = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic run_scan(input logic [NSTEP-1:0] m, input logic mid_start);
    cur_mask = m;
    clear_stats();
    mode_i = 3'd6;
    pulse_start();
    if (mid_start) begin
      repeat (30) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (!(done_o && !busy_o)) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; mode_i = 3'd0;
    cur_mask = '0; hold_upd_idx = -1; hold_test_idx = -1;
    upd_rises = 0; test_rises = 0; last_test_idx = -1;
    order_ok = 1'b1; busy_seen = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy_o && !done_o && !err_o, "R1 flags", {busy_o, done_o, err_o}, 0);
    chk(!upd_req_o && !test_req_o, "R1 requests", {upd_req_o, test_req_o}, 0);
    chk(tune_val_o == 0, "R1 tune", tune_val_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // vector table: R3 R4 R5 R6
    for (int i = 0; i < NVEC; i++) begin
      run_scan(VECS[i].mask, 1'b0);
      chk(tune_val_o == VECS[i].val, VECS[i].err ? "R6 tune" : "R5 tune",
          tune_val_o, VECS[i].val);
      chk(err_o == VECS[i].err, VECS[i].err ? "R6 err" : "R5 err", err_o, VECS[i].err);
      chk(done_o, "R9 done", done_o, 1);
      chk(upd_rises == (VECS[i].err ? 80 : 82), "R4 update count", upd_rises,
          VECS[i].err ? 80 : 82);
      chk(test_rises == NSTEP && order_ok, "R3 test order/count", test_rises, NSTEP);
    end

    // R2: after the failed scan, a non-tunable start clears err, keeps tune
    clear_stats();
    mode_i = 3'd3;
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(done_o && !err_o, "R2 immediate done", {done_o, err_o}, 2);
    repeat (4) @(negedge clk);
    chk(!busy_seen && upd_rises == 0, "R2 no activity", upd_rises, 0);
    chk(tune_val_o == 6'd39, "R2 tune unchanged", tune_val_o, 39);

    // R7: update never acknowledged at step 20
    hold_upd_idx = 20;
    run_scan({NSTEP{1'b1}}, 1'b0);
    hold_upd_idx = -1;
    chk(tune_val_o == 6'd9, "R7 tune", tune_val_o, 9);
    chk(test_rises == NSTEP - 1, "R7 test skipped", test_rises, NSTEP - 1);
    chk(upd_rises == 81, "R7 update count", upd_rises, 81);

    // R8: verdict never arrives at step 0
    hold_test_idx = 0;
    run_scan({NSTEP{1'b1}}, 1'b0);
    hold_test_idx = -1;
    chk(tune_val_o == 6'd20, "R8 tune", tune_val_o, 20);
    chk(!err_o, "R8 err", err_o, 0);

    // R9: start while busy is ignored
    run_scan(VECS[1].mask, 1'b1);
    chk(tune_val_o == VECS[1].val, "R9 tune after mid start", tune_val_o, VECS[1].val);
    chk(test_rises == NSTEP, "R9 single scan", test_rises, NSTEP);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule